// File: doc/BRIEF.md
# Cascaded-Divider Peripheral Clock-Enable Generator

This block turns one of three free-running source strobes into a slower, gateable clock-enable pulse for a peripheral. Each source strobe is a single-cycle pulse on the system clock and stands for one period of a PLL output. The block has several identical channels. Each channel picks a source with a 2-bit select, divides it through two programmable 6-bit counters placed in series, and ANDs the result with a gate. The whole chain stays on the system clock and is made of enables only, so no real clock is switched.

Software writes each channel through a simple byte-addressed write port. A channel has a control word, which holds the select and both divisors, at a base offset. Its gate word sits 8 bytes above that base. The gate bit uses disable polarity: writing 1 stops the output and writing 0 lets it run. The division counters keep running while the channel is gated, so re-enabling a channel does not restart its phase.

Top module: `perclk_divgen`

## Requirements
- R1: While reset is asserted every `clk_en_o` bit is 0. After reset every channel has source select 0, both divisors equal to 1 and the gate open.
- R2: Source select sits in control bits 5:4. Codes 0 and 1 pick `src_stb_i[0]`, code 2 picks `src_stb_i[1]` and code 3 picks `src_stb_i[2]`.
- R3: The first divisor sits in control bits 13:8 and the second in bits 25:20. Both are one-based, so a channel emits one pulse for every (first × second) selected source strobes.
- R4: A divisor field of 0 acts as divide-by-1.
- R5: The gate is bit 0 of the word 8 bytes above a channel's control word. A 1 there forces the output to 0 and a 0 lets it pulse. The dividers keep counting while the output is gated.
- R6: Channel i has its control word at byte address 0x10·i and its gate word at 0x10·i+8. A write to any other address changes no channel.
- R7: Every output pulse lasts one cycle. It appears in the cycle after the source strobe that completes the count, so an output pulse is always preceded by a source strobe.
- R8: A divisor written while a stage is counting has no effect until that stage's next output boundary. From that boundary on, the new value sets the length of the following count.
- R9: Both stages start at a count boundary after reset, so the first selected source strobe produces an output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_stb_i | input | NUM_SRC | Source period strobes: [0] IO PLL, [1] ARM PLL, [2] DDR PLL |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register byte address |
| wr_data_i | input | DATA_W | Register write data |
| clk_en_o | output | NUM_CH | Per-channel divided and gated clock-enable pulse |

## Verification
The assertions assume that every source strobe is a clean, synchronous single-cycle sample. They also assume that register writes arrive as one-cycle pulses with a stable address and data. The bench drives all inputs on the falling edge and produces strobes from an LFSR, so they are never X and are always aligned to the clock. It mixes sparse strobes, dense strobes and every-cycle strobes. It writes to both decoded and undecoded addresses, and it changes divisors in the middle of a count to exercise the boundary rule.

// File: rtl/perclk_pkg.sv
package perclk_pkg;

  localparam int DIV_W    = 6;
  localparam int SEL_W    = 2;
  localparam int NUM_SRC  = 3;
  localparam int SEL_LSB  = 4;
  localparam int DIVA_LSB = 8;
  localparam int DIVB_LSB = 20;
  localparam int GATE_BIT = 0;
  localparam int SRC_IDX_W = $clog2(NUM_SRC);

  typedef enum logic [SRC_IDX_W-1:0] {
    SRC_IO  = 0,
    SRC_ARM = 1,
    SRC_DDR = 2
  } src_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div_a;
    logic [DIV_W-1:0] div_b;
  } ctrl_t;

  // Select code to source strobe index; codes 0 and 1 alias onto the IO source.
  function automatic src_e sel_to_src(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd2:    return SRC_ARM;
      2'd3:    return SRC_DDR;
      default: return SRC_IO;
    endcase
  endfunction

endpackage

// File: rtl/perclk_regs.sv
module perclk_regs
  import perclk_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int CH_STRIDE = 16,
  parameter int GATE_OFS  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  output ctrl_t [NUM_CH-1:0]       ctrl_o,
  output logic  [NUM_CH-1:0]       gate_off_o
);

  logic unused_data;
  assign unused_data = ^wr_data_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CH_STRIDE * g);
    localparam logic [ADDR_W-1:0] GATE_A = ADDR_W'(CH_STRIDE * g + GATE_OFS);

    ctrl_t ctrl_d, ctrl_q;
    logic  gate_d, gate_q;
    logic  ctrl_we, gate_we;

    always_comb begin
      ctrl_we      = wr_en_i && (wr_addr_i == CTRL_A);
      gate_we      = wr_en_i && (wr_addr_i == GATE_A);
      ctrl_d.sel   = wr_data_i[SEL_LSB  +: SEL_W];
      ctrl_d.div_a = wr_data_i[DIVA_LSB +: DIV_W];
      ctrl_d.div_b = wr_data_i[DIVB_LSB +: DIV_W];
      gate_d       = wr_data_i[GATE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q.sel   <= '0;
        ctrl_q.div_a <= DIV_W'(1);
        ctrl_q.div_b <= DIV_W'(1);
      end else if (ctrl_we) begin
        ctrl_q <= ctrl_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gate_q <= 1'b0;
      end else if (gate_we) begin
        gate_q <= gate_d;
      end
    end

    assign ctrl_o[g]     = ctrl_q;
    assign gate_off_o[g] = gate_q;
  end

endmodule

// File: rtl/perclk_stage.sv
module perclk_stage #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             stb_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d, reload;
  logic             at_edge;

  always_comb begin
    at_edge = (cnt_q == '0);
    // Zero and one both reload to zero: a pulse on every input strobe.
    reload  = (div_i == '0) ? '0 : div_i - DIV_W'(1);
    cnt_d   = at_edge ? reload : cnt_q - DIV_W'(1);
    stb_o   = stb_i && at_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (stb_i) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/perclk_chan.sv
module perclk_chan
  import perclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_stb_i,
  input  ctrl_t              ctrl_i,
  input  logic               gate_off_i,
  output logic               clk_en_o
);

  logic sel_stb, stb_a, stb_b;
  logic en_d, en_q;
  src_e src_idx;

  always_comb begin
    src_idx = sel_to_src(ctrl_i.sel);
    sel_stb = src_stb_i[src_idx];
  end

  perclk_stage #(.DIV_W(DIV_W)) u_stage_a (
    .clk   (clk),
    .rst_n (rst_n),
    .stb_i (sel_stb),
    .div_i (ctrl_i.div_a),
    .stb_o (stb_a)
  );

  perclk_stage #(.DIV_W(DIV_W)) u_stage_b (
    .clk   (clk),
    .rst_n (rst_n),
    .stb_i (stb_a),
    .div_i (ctrl_i.div_b),
    .stb_o (stb_b)
  );

  assign en_d = stb_b && !gate_off_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign clk_en_o = en_q;

endmodule

// File: rtl/perclk_divgen.sv
module perclk_divgen
  import perclk_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int CH_STRIDE = 16,
  parameter int GATE_OFS  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_stb_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [NUM_CH-1:0]  clk_en_o
);

  ctrl_t [NUM_CH-1:0] ctrl;
  logic  [NUM_CH-1:0] gate_off;

  perclk_regs #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CH_STRIDE (CH_STRIDE),
    .GATE_OFS  (GATE_OFS)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .ctrl_o     (ctrl),
    .gate_off_o (gate_off)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    perclk_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_stb_i  (src_stb_i),
      .ctrl_i     (ctrl[g]),
      .gate_off_i (gate_off[g]),
      .clk_en_o   (clk_en_o[g])
    );
  end

endmodule

// File: rtl/perclk_divgen_chk.sv
module perclk_divgen_chk #(
  parameter int NUM_CH    = 4,
  parameter int NUM_SRC   = 3,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int CH_STRIDE = 16,
  parameter int GATE_OFS  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_stb_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [NUM_CH-1:0]  clk_en_o,
  input logic [NUM_CH-1:0]  gate_off
);

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (clk_en_o == '0);
    end
  end

  // R7
  pulse_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clk_en_o) |-> $past(|src_stb_i));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] GATE_A = ADDR_W'(CH_STRIDE * g + GATE_OFS);

    // R5
    gated_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_o[g] |-> !$past(gate_off[g]));

    // R6
    gate_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_addr_i == GATE_A) |=> (gate_off[g] == $past(wr_data_i[0])));
  end

endmodule

bind perclk_divgen perclk_divgen_chk #(
  .NUM_CH    (NUM_CH),
  .NUM_SRC   (perclk_pkg::NUM_SRC),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CH_STRIDE (CH_STRIDE),
  .GATE_OFS  (GATE_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_stb_i (src_stb_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .clk_en_o  (clk_en_o),
  .gate_off  (gate_off)
);

// File: tb/perclk_divgen_tb.sv
module perclk_divgen_tb;

  localparam int NCH = 4;

  logic        clk;
  logic        rst_n;
  logic [2:0]  src_stb;
  logic        wr_en;
  logic [5:0]  wr_addr;
  logic [31:0] wr_data;
  logic [NCH-1:0] clk_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  int sel_m [NCH];
  int da_m  [NCH];
  int db_m  [NCH];
  int ca_m  [NCH];
  int cb_m  [NCH];
  bit gate_m[NCH];
  bit exp_en[NCH];

  perclk_divgen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_stb_i (src_stb),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .clk_en_o  (clk_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit pick(input logic [2:0] s, input int sel);
    if (sel == 2) return s[1];
    if (sel == 3) return s[2];
    return s[0];
  endfunction

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        sel_m[c] = 0; da_m[c] = 1; db_m[c] = 1;
        ca_m[c] = 0; cb_m[c] = 0; gate_m[c] = 0; exp_en[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit s, oa, ob;
        s = pick(src_stb, sel_m[c]);
        oa = 0; ob = 0;
        if (s) begin
          if (ca_m[c] == 0) begin oa = 1; ca_m[c] = eff(da_m[c]) - 1; end
          else ca_m[c]--;
        end
        if (oa) begin
          if (cb_m[c] == 0) begin ob = 1; cb_m[c] = eff(db_m[c]) - 1; end
          else cb_m[c]--;
        end
        exp_en[c] = ob && !gate_m[c];
      end
      if (wr_en) begin
        for (int c = 0; c < NCH; c++) begin
          if (int'(wr_addr) == 16 * c) begin
            sel_m[c] = int'(wr_data[5:4]);
            da_m[c]  = int'(wr_data[13:8]);
            db_m[c]  = int'(wr_data[25:20]);
          end
          if (int'(wr_addr) == 16 * c + 8) gate_m[c] = wr_data[0];
        end
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        checks++;
        if (clk_en[c] !== exp_en[c]) begin
          errors++;
          $display("FAIL %s ch%0d at cycle %0d: actual %b expected %b",
                   tag, c, cycles, clk_en[c], exp_en[c]);
        end
      end
    end
  end

  function automatic logic [31:0] mk(input int sel, input int a, input int b);
    return (32'(b) << 20) | (32'(a) << 8) | (32'(sel) << 4);
  endfunction

  task automatic run(input int n, input bit rnd, input logic [2:0] mask);
    repeat (n) begin
      @(negedge clk);
      lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      src_stb = rnd ? (lfsr[2:0] & mask) : mask;
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 6'(addr);
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; src_stb = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    // R1: outputs quiet during reset
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (clk_en !== '0) begin
        errors++;
        $display("FAIL R1 reset: actual %b expected 0000", clk_en);
      end
    end
    rst_n = 1'b1;

    // R9 and R1 defaults: every IO strobe passes straight through
    tag = "R9";
    run(20, 0, 3'b001);

    // R2: select decode with distinct source patterns
    tag = "R2";
    wr(16'h00, mk(1, 1, 1)); wr(16'h10, mk(2, 1, 1));
    wr(16'h20, mk(3, 1, 1)); wr(16'h30, mk(0, 1, 1));
    run(200, 1, 3'b111);

    // R3: product of two one-based divisors
    tag = "R3";
    wr(16'h00, mk(2, 3, 2)); wr(16'h10, mk(0, 5, 4));
    wr(16'h20, mk(1, 63, 2)); wr(16'h30, mk(3, 2, 7));
    run(600, 1, 3'b111);
    run(300, 0, 3'b111);

    // R4: zero divisors act as one
    tag = "R4";
    wr(16'h00, mk(0, 0, 0)); wr(16'h10, mk(2, 0, 3)); wr(16'h20, mk(3, 4, 0));
    run(200, 1, 3'b111);

    // R5: gate with disable polarity, counting continues underneath
    tag = "R5";
    wr(16'h18, 32'h1); wr(16'h38, 32'h1);
    run(150, 1, 3'b111);
    wr(16'h18, 32'h0); wr(16'h38, 32'hFFFF_FFFE);
    run(100, 1, 3'b111);

    // R6: undecoded addresses leave every channel untouched
    tag = "R6";
    wr(16'h04, 32'hFFFF_FFFF); wr(16'h0C, 32'hFFFF_FFFF);
    wr(16'h14, mk(3, 9, 9));   wr(16'h2C, 32'h1);
    wr(16'h3C, 32'h1);         wr(16'h24, mk(2, 2, 2));
    run(200, 1, 3'b111);

    // R8: divisor changes mid-count only apply at the boundary
    tag = "R8";
    wr(16'h00, mk(0, 4, 3));
    run(37, 0, 3'b001);
    wr(16'h00, mk(0, 2, 5));
    run(50, 0, 3'b001);
    wr(16'h00, mk(0, 7, 1));
    run(100, 1, 3'b111);

    // R7: single-cycle pulses one cycle after sparse strobes
    tag = "R7";
    wr(16'h00, mk(0, 1, 1)); wr(16'h10, mk(0, 1, 1));
    wr(16'h20, mk(1, 1, 1)); wr(16'h30, mk(0, 1, 1));
    run(100, 1, 3'b001);
    run(4, 0, 3'b000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule